// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Block

This block gives software a 32-bit bank of general-purpose I/O through a simple word-wide register bus. A direction register marks each pin as an output (bit set) or an input (bit clear). A level register holds the value presented on the output pins. Software never writes the level register directly. It sets bits through a set port at offset 0x08 and clears them through a clear port at offset 0x0C. Either write only has an effect when its value shares at least one bit with the direction register. When it does, the whole written value is applied, including bits that belong to input pins.

An auxiliary 32-bit register at offset 0x20 can be read and written freely. Three edge-control offsets (0x10, 0x14, 0x18) accept writes and discard them. An access to any undecoded or unaligned offset raises a one-cycle error pulse, as does a set or clear write with no direction overlap. Nine interrupt lines (eight for the low pins and one combined line) are present on the boundary and always driven low.

A small bus state machine sequences every access:
- ST_IDLE: no response is pending.
- ST_RDATA: a legal read has just been captured.
- ST_FAULT: the previous access was rejected. This state is the only source of the error pulse.

The transitions are:
- go_read: legal read, to ST_RDATA.
- go_fault: rejected read or write, to ST_FAULT.
- go_write: accepted write, to ST_IDLE.
- go_rest: no access, to ST_IDLE.

Each transition is taken from any state.

Top module: `gpio_regblk`

## Requirements
- R1: While reset is held, and in the first cycle after it, gpio_out, gpio_oe, rdata and err are all zero, and the auxiliary register reads back zero.
- R2: A write to offset 0x04 loads the direction register. gpio_oe shows the new value from the next cycle, a 1 bit meaning output. A read of 0x04 returns it.
- R3: A read of offset 0x00 returns the level register, which also drives gpio_out. A write to 0x00 leaves gpio_out unchanged and raises err.
- R4: A write to offset 0x08 whose value overlaps the direction register ORs the entire value into the level register, without raising err.
- R5: A write to offset 0x0C whose value overlaps the direction register clears every written bit in the level register, without raising err.
- R6: A write to 0x08 or 0x0C whose value has no bit in common with the direction register leaves the level register unchanged and raises err.
- R7: Writes to offsets 0x10, 0x14 and 0x18 change no output and raise no err. Reads of those offsets return zero and raise err.
- R8: Offset 0x20 is a read/write auxiliary register. Writing it changes neither gpio_out nor gpio_oe.
- R9: Read data appears on rdata in the cycle after rd_en and holds until the next read.
- R10: A read of any offset other than 0x00, 0x04 or 0x20 returns zero, and a write to any offset other than 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 or 0x20 is ignored. Both raise err, and so do misaligned addresses. err is high for exactly one cycle, the cycle after each rejected access.
- R11: irq_low and irq_high stay zero at all times.
- R12: When wr_en and rd_en are both high, only the write is performed. rdata keeps its previous value and no read error is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (8) | Byte offset of the access |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| err | output | 1 | One-cycle pulse after a rejected access |
| gpio_out | output | DATA_W (32) | Level register value |
| gpio_oe | output | DATA_W (32) | Direction register value, 1 = output |
| irq_low | output | N_LOW_IRQ (8) | Per-pin interrupt lines, held low |
| irq_high | output | 1 | Combined interrupt line, held low |

## Verification
The assertions check the following on every cycle:
- The interrupt lines are quiet.
- err only follows an access.
- gpio_out moves only after a set or clear write, and gpio_oe only after a direction write.
- A non-overlapping set or clear leaves the levels frozen and pulses err.
- A rejected read returns zero.

Only the bench's scenarios can show that each register reads back what was written, and that a set writes bits of input pins too. They also show that the edge offsets are inert for writes yet fault on reads, that rdata holds across idle cycles, and that a combined read and write performs only the write.

// File: rtl/gpio_regblk_pkg.sv
package gpio_regblk_pkg;

    // Byte offsets decoded by the block; the software map depends on them.
    localparam logic [7:0] OFS_LEVEL = 8'h00;
    localparam logic [7:0] OFS_DIR   = 8'h04;
    localparam logic [7:0] OFS_SET   = 8'h08;
    localparam logic [7:0] OFS_CLR   = 8'h0C;
    localparam logic [7:0] OFS_EDGR  = 8'h10;
    localparam logic [7:0] OFS_EDGF  = 8'h14;
    localparam logic [7:0] OFS_EDGS  = 8'h18;
    localparam logic [7:0] OFS_AUX   = 8'h20;

    typedef enum logic [2:0] {
        RGN_LEVEL,
        RGN_DIR,
        RGN_SET,
        RGN_CLR,
        RGN_EDGE,
        RGN_AUX,
        RGN_NONE
    } gpio_rgn_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RDATA,
        ST_FAULT
    } gpio_bus_st_e;

    typedef struct packed {
        gpio_rgn_e rgn;
        logic      rd_ok;
        logic      wr_ok;
        logic      masked;
    } gpio_dec_t;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_regblk_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_dec_t         dec
);

    always_comb begin
        dec.rgn    = RGN_NONE;
        dec.rd_ok  = 1'b0;
        dec.wr_ok  = 1'b0;
        dec.masked = 1'b0;
        case (addr)
            ADDR_W'(OFS_LEVEL): begin
                dec.rgn   = RGN_LEVEL;
                dec.rd_ok = 1'b1;
            end
            ADDR_W'(OFS_DIR): begin
                dec.rgn   = RGN_DIR;
                dec.rd_ok = 1'b1;
                dec.wr_ok = 1'b1;
            end
            ADDR_W'(OFS_SET): begin
                dec.rgn    = RGN_SET;
                dec.wr_ok  = 1'b1;
                dec.masked = 1'b1;
            end
            ADDR_W'(OFS_CLR): begin
                dec.rgn    = RGN_CLR;
                dec.wr_ok  = 1'b1;
                dec.masked = 1'b1;
            end
            ADDR_W'(OFS_EDGR),
            ADDR_W'(OFS_EDGF),
            ADDR_W'(OFS_EDGS): begin
                dec.rgn   = RGN_EDGE;
                dec.wr_ok = 1'b1;
            end
            ADDR_W'(OFS_AUX): begin
                dec.rgn   = RGN_AUX;
                dec.rd_ok = 1'b1;
                dec.wr_ok = 1'b1;
            end
            default: begin
                dec.rgn = RGN_NONE;
            end
        endcase
    end

endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_regblk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      rd_en,
    input  gpio_dec_t dec,
    input  logic      mask_hit,
    output logic      wr_commit,
    output logic      rd_capture,
    output logic      err_pulse
);

    gpio_bus_st_e state;
    gpio_bus_st_e state_nxt;
    logic         wr_fault;
    logic         rd_fault;
    logic         rd_only;

    // Access classification; a write always takes precedence over a read.
    always_comb begin
        rd_only  = rd_en && !wr_en;
        wr_fault = wr_en && (!dec.wr_ok || (dec.masked && !mask_hit));
        rd_fault = rd_only && !dec.rd_ok;
    end

    // Transitions: go_write, go_read, go_fault, go_rest (from any state).
    always_comb begin
        state_nxt = ST_IDLE;
        if (wr_en) begin
            state_nxt = wr_fault ? ST_FAULT : ST_IDLE;
        end else if (rd_en) begin
            state_nxt = rd_fault ? ST_FAULT : ST_RDATA;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Outputs: commit strobes follow the current access, err follows state.
    always_comb begin
        wr_commit  = wr_en && !wr_fault;
        rd_capture = rd_only;
        err_pulse  = 1'b0;
        unique case (state)
            ST_IDLE:  err_pulse = 1'b0;
            ST_RDATA: err_pulse = 1'b0;
            ST_FAULT: err_pulse = 1'b1;
            default:  err_pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_regblk_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_commit,
    input  logic              rd_capture,
    input  gpio_dec_t         dec,
    input  logic [DATA_W-1:0] wdata,
    output logic              mask_hit,
    output logic [DATA_W-1:0] level_q,
    output logic [DATA_W-1:0] dir_q,
    output logic [DATA_W-1:0] rdata_q
);

    logic [DATA_W-1:0] aux_q;
    logic [DATA_W-1:0] rd_mux;

    assign mask_hit = |(dir_q & wdata);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            dir_q   <= '0;
            aux_q   <= '0;
        end else if (wr_commit) begin
            unique case (dec.rgn)
                RGN_DIR:  dir_q   <= wdata;
                RGN_SET:  level_q <= level_q | wdata;
                RGN_CLR:  level_q <= level_q & ~wdata;
                RGN_AUX:  aux_q   <= wdata;
                RGN_EDGE: level_q <= level_q;
                default:  level_q <= level_q;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        if (dec.rd_ok) begin
            unique case (dec.rgn)
                RGN_LEVEL: rd_mux = level_q;
                RGN_DIR:   rd_mux = dir_q;
                RGN_AUX:   rd_mux = aux_q;
                default:   rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_capture) begin
            rdata_q <= rd_mux;
        end
    end

endmodule

// File: rtl/gpio_irq_tie.sv
module gpio_irq_tie #(
    parameter int unsigned N_LOW_IRQ = 8
) (
    output logic [N_LOW_IRQ-1:0] irq_low,
    output logic                 irq_high
);

    for (genvar g = 0; g < N_LOW_IRQ; g++) begin : g_low
        assign irq_low[g] = 1'b0;
    end
    assign irq_high = 1'b0;

endmodule

// File: rtl/gpio_regblk.sv
module gpio_regblk
    import gpio_regblk_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned N_LOW_IRQ = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 err,
    output logic [DATA_W-1:0]    gpio_out,
    output logic [DATA_W-1:0]    gpio_oe,
    output logic [N_LOW_IRQ-1:0] irq_low,
    output logic                 irq_high
);

    gpio_dec_t dec;
    logic      mask_hit;
    logic      wr_commit;
    logic      rd_capture;

    gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    gpio_bus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .dec        (dec),
        .mask_hit   (mask_hit),
        .wr_commit  (wr_commit),
        .rd_capture (rd_capture),
        .err_pulse  (err)
    );

    gpio_reg_file #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_commit  (wr_commit),
        .rd_capture (rd_capture),
        .dec        (dec),
        .wdata      (wdata),
        .mask_hit   (mask_hit),
        .level_q    (gpio_out),
        .dir_q      (gpio_oe),
        .rdata_q    (rdata)
    );

    gpio_irq_tie #(.N_LOW_IRQ(N_LOW_IRQ)) u_irq (
        .irq_low  (irq_low),
        .irq_high (irq_high)
    );

endmodule

// File: rtl/gpio_regblk_chk.sv
module gpio_regblk_chk
    import gpio_regblk_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned N_LOW_IRQ = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    addr,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [DATA_W-1:0]    wdata,
    input logic [DATA_W-1:0]    rdata,
    input logic                 err,
    input logic [DATA_W-1:0]    gpio_out,
    input logic [DATA_W-1:0]    gpio_oe,
    input logic [N_LOW_IRQ-1:0] irq_low,
    input logic                 irq_high
);

    logic is_setclr;
    logic is_dir;
    logic is_rd_legal;
    logic no_overlap;

    assign is_setclr   = (addr == ADDR_W'(OFS_SET)) || (addr == ADDR_W'(OFS_CLR));
    assign is_dir      = (addr == ADDR_W'(OFS_DIR));
    assign is_rd_legal = (addr == ADDR_W'(OFS_LEVEL)) || is_dir || (addr == ADDR_W'(OFS_AUX));
    assign no_overlap  = ((gpio_oe & wdata) == '0);

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_low == '0) && !irq_high); // R11

    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(wr_en || rd_en)); // R10

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && is_setclr) |=> $stable(gpio_out)); // R3

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && is_dir) |=> $stable(gpio_oe)); // R2

    AST_NO_OVERLAP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_setclr && no_overlap) |=> ($stable(gpio_out) && err)); // R6

    AST_SET_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == ADDR_W'(OFS_SET)) && !no_overlap)
        |=> ((gpio_out == ($past(gpio_out) | $past(wdata))) && !err)); // R4

    AST_CLR_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == ADDR_W'(OFS_CLR)) && !no_overlap)
        |=> ((gpio_out == ($past(gpio_out) & ~$past(wdata))) && !err)); // R5

    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !is_rd_legal) |=> ((rdata == '0) && err)); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en) |=> $stable(rdata)); // R12

endmodule

bind gpio_regblk gpio_regblk_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .N_LOW_IRQ (N_LOW_IRQ)
) u_chk (.*);

// File: tb/tb_gpio_regblk.sv
`timescale 1ns/1ps
module tb_gpio_regblk;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic [31:0] gpio_out;
    logic [31:0] gpio_oe;
    logic [7:0]  irq_low;
    logic        irq_high;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    // Reference model state.
    logic [31:0] m_level, m_dir, m_aux, m_rdata;
    logic        m_err;

    always #2.5 clk = ~clk;

    gpio_regblk dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .err(err), .gpio_out(gpio_out),
        .gpio_oe(gpio_oe), .irq_low(irq_low), .irq_high(irq_high)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    // Behavioural model, advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_level = 0; m_dir = 0; m_aux = 0; m_rdata = 0; m_err = 0;
        end else begin
            m_err = 0;
            if (wr_en) begin
                case (addr)
                    8'h04: m_dir = wdata;
                    8'h08: if ((m_dir & wdata) != 0) m_level = m_level | wdata; else m_err = 1;
                    8'h0C: if ((m_dir & wdata) != 0) m_level = m_level & ~wdata; else m_err = 1;
                    8'h10, 8'h14, 8'h18: ;
                    8'h20: m_aux = wdata;
                    default: m_err = 1;
                endcase
            end else if (rd_en) begin
                case (addr)
                    8'h00: m_rdata = m_level;
                    8'h04: m_rdata = m_dir;
                    8'h20: m_rdata = m_aux;
                    default: begin m_rdata = 0; m_err = 1; end
                endcase
            end
        end
    end

    // Compare on every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (live) begin
            chk(gpio_out == m_level, "R4", "cycle gpio_out", gpio_out, m_level);
            chk(gpio_oe == m_dir, "R2", "cycle gpio_oe", gpio_oe, m_dir);
            chk(err == m_err, "R10", "cycle err", {31'b0, err}, {31'b0, m_err});
            chk(rdata == m_rdata, "R9", "cycle rdata", rdata, m_rdata);
            chk({irq_low, irq_high} == 9'b0, "R11", "cycle irq", {23'b0, irq_low, irq_high}, 32'h0);
        end
    end

    // One access, then outputs are inspected at the following falling edge.
    task automatic acc(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input bit exp_err, input string req);
        acc(0, 1, a, 32'h0);
        chk(rdata == exp, req, "read data", rdata, exp);
        chk(err == exp_err, req, "read err", {31'b0, err}, {31'b0, exp_err});
    endtask

    task automatic wr_chk(input logic [7:0] a, input logic [31:0] d, input bit exp_err, input string req);
        acc(1, 0, a, d);
        chk(err == exp_err, req, "write err", {31'b0, err}, {31'b0, exp_err});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (4) @(negedge clk);
        // R1: outputs during reset
        chk(gpio_out == 0 && gpio_oe == 0, "R1", "reset gpio", gpio_out | gpio_oe, 32'h0);
        chk(rdata == 0 && !err, "R1", "reset bus", rdata | {31'b0, err}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        live = 1;
        chk(gpio_out == 0 && gpio_oe == 0 && !err, "R1", "after reset", gpio_out, 32'h0);
        rd_chk(8'h20, 32'h0, 0, "R1");

        // R2: direction
        wr_chk(8'h04, 32'h0000_00FF, 0, "R2");
        chk(gpio_oe == 32'h0000_00FF, "R2", "gpio_oe", gpio_oe, 32'h0000_00FF);
        rd_chk(8'h04, 32'h0000_00FF, 0, "R2");

        // R4: set applies whole value, including input-pin bits
        wr_chk(8'h08, 32'h0000_0F0F, 0, "R4");
        chk(gpio_out == 32'h0000_0F0F, "R4", "set", gpio_out, 32'h0000_0F0F);
        // R5: clear
        wr_chk(8'h0C, 32'h0000_0003, 0, "R5");
        chk(gpio_out == 32'h0000_0F0C, "R5", "clear", gpio_out, 32'h0000_0F0C);

        // R6: no overlap on set and on clear
        wr_chk(8'h08, 32'hFF00_0000, 1, "R6");
        chk(gpio_out == 32'h0000_0F0C, "R6", "set no overlap", gpio_out, 32'h0000_0F0C);
        wr_chk(8'h0C, 32'h0000_0100, 1, "R6");
        chk(gpio_out == 32'h0000_0F0C, "R6", "clear no overlap", gpio_out, 32'h0000_0F0C);

        // R3: level read, direct write refused
        rd_chk(8'h00, 32'h0000_0F0C, 0, "R3");
        wr_chk(8'h00, 32'h1234_5678, 1, "R3");
        chk(gpio_out == 32'h0000_0F0C, "R3", "direct write", gpio_out, 32'h0000_0F0C);

        // R7: edge offsets
        wr_chk(8'h10, 32'hFFFF_FFFF, 0, "R7");
        wr_chk(8'h14, 32'hFFFF_FFFF, 0, "R7");
        wr_chk(8'h18, 32'hFFFF_FFFF, 0, "R7");
        chk(gpio_out == 32'h0000_0F0C && gpio_oe == 32'h0000_00FF, "R7", "edge inert", gpio_out, 32'h0000_0F0C);
        rd_chk(8'h14, 32'h0, 1, "R7");

        // R8: auxiliary register
        wr_chk(8'h20, 32'hDEAD_BEEF, 0, "R8");
        rd_chk(8'h20, 32'hDEAD_BEEF, 0, "R8");
        chk(gpio_out == 32'h0000_0F0C && gpio_oe == 32'h0000_00FF, "R8", "aux isolated", gpio_oe, 32'h0000_00FF);

        // R9: read data holds across idle cycles
        repeat (3) @(negedge clk);
        chk(rdata == 32'hDEAD_BEEF, "R9", "hold", rdata, 32'hDEAD_BEEF);

        // R10: bad offsets and misaligned
        rd_chk(8'h24, 32'h0, 1, "R10");
        rd_chk(8'h02, 32'h0, 1, "R10");
        wr_chk(8'h1C, 32'hFFFF_FFFF, 1, "R10");
        @(negedge clk);
        chk(!err, "R10", "err one cycle", {31'b0, err}, 32'h0);
        // back-to-back rejected writes give err in both following cycles
        @(negedge clk); wr_en = 1; addr = 8'h28; wdata = 32'h1;
        @(negedge clk); addr = 8'h2C;
        chk(err, "R10", "b2b first", {31'b0, err}, 32'h1);
        @(negedge clk); wr_en = 0;
        chk(err, "R10", "b2b second", {31'b0, err}, 32'h1);

        // R12: write wins over simultaneous read
        rd_chk(8'h04, 32'h0000_00FF, 0, "R12");
        held = rdata;
        acc(1, 1, 8'h04, 32'h0000_F000);
        chk(gpio_oe == 32'h0000_F000, "R12", "write done", gpio_oe, 32'h0000_F000);
        chk(rdata == held && !err, "R12", "read ignored", rdata, held);
        acc(1, 1, 8'h24, 32'h0);
        chk(rdata == held, "R12", "bad read ignored", rdata, held);

        // Random traffic compared against the model every cycle.
        for (int i = 0; i < 600; i++) begin
            logic [7:0] pick [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h02};
            @(negedge clk);
            wr_en = ($urandom % 3) == 0;
            rd_en = ($urandom % 3) == 0;
            addr  = pick[$urandom % 10];
            wdata = ($urandom % 2) ? $urandom : ($urandom & 32'h0000_00FF);
        end
        @(negedge clk); wr_en = 0; rd_en = 0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule